// File: doc/BRIEF.md
# Interrupt Request Latch with Vectoring

This block holds the request state for two interrupt sources: an external pin and a serial receiver. For each source it supplies the vector that the CPU fetches during its acknowledge sequence. The pin source runs in one of two modes, chosen by software through a small write-only register port.

- **Edge mode:** a synchronized rising edge sets a flag, and the flag holds until it is cleared.
- **Level mode:** the flag is bypassed and the request follows the synchronized pin.

The clearing rules are deliberately uneven:

- Moving the pin into level mode wipes the flag, but moving it back to edge mode keeps whatever the flag held.
- The pin flag can be cleared by writing a source code to the clear register.
- The receive flag ignores that register. It drops only on a strobe marking a read of the receive buffer, or on reset.

Acknowledge is a two-step handshake. An accept pulse opens the sequence, and a later vector-read pulse samples the pending sources.

- If the pin source is pending, it wins over the receive source.
- If nothing is pending at that moment (for example, software cleared the flag in between), the block returns a fixed default vector.

The vector leaves as a one-cycle valid-qualified word with no ready. The vector-read pulse is the consumer's own request, so back-pressure cannot arise. The word must be taken in the cycle that `vec_valid` is high.

Top module: `irq_latch_vec`

## Requirements
- R1: After synchronous reset, the following all read 0: `pin_req`, `rx_flag`, `vec_valid` and `pin_level_mode` (0 means edge mode).
- R2: In edge mode, a low-to-high change on `pin_in` raises `pin_req` on the third rising clock edge after the change. Through the two synchronizer flops and the flag, it then holds after the pin returns low.
- R3: In level mode, `pin_req` equals `pin_in` delayed by two clock edges. This includes dropping when the pin falls.
- R4: Writing level mode clears the latched pin flag. When switched back to edge mode with the pin low, `pin_req` stays 0.
- R5: Switching from level to edge mode keeps a request that was high in level mode. The request remains after the pin falls until it is cleared.
- R6: In edge mode, a write of 0x0A to register address 1 clears the pin flag on that edge. Any other data value at address 1 leaves it unchanged.
- R7: A one-cycle `rx_req` sets `rx_flag` on the next edge. Only `rx_buf_rd` or reset clears it. Writes to the clear register (0x0A included) have no effect on it.
- R8: A vector read that follows an accept drives `vec_valid` high for one cycle after the read edge. If `pin_req` is high, `vec_out` is the pin vector (default 0x0028). Otherwise, if `rx_flag` is high, it is the receive vector (default 0x0050). The pin source wins when both are high.
- R9: When no source is pending at the vector read, `vec_out` is 0x0008 and `vec_addr` is 0xFFFF08. This holds even when a flag was cleared after the accept.
- R10: A vector read that selects the pin source in edge mode clears the pin flag. In level mode the pin request is not cleared, and `rx_flag` is never cleared by a vector read.
- R11: A vector read with no accept outstanding is ignored: `vec_valid` stays 0. Each accept yields at most one vector.
- R12: Register address 0, data bit 0, selects the pin mode (1 = level, 0 = edge) and is reflected on `pin_level_mode`. Writes to other addresses do not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 1 | Asynchronous external interrupt pin |
| rx_req | input | 1 | Serial receive request pulse |
| rx_buf_rd | input | 1 | Strobe marking a receive buffer read |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 clear) |
| reg_wdata | input | 8 | Register write data |
| ack_accept | input | 1 | CPU has accepted an interrupt |
| ack_vec_rd | input | 1 | CPU reads the vector |
| pin_req | output | 1 | Pin interrupt request |
| rx_flag | output | 1 | Receive interrupt request flag |
| pin_level_mode | output | 1 | 1 when the pin is in level mode |
| vec_valid | output | 1 | Vector word valid, one cycle |
| vec_out | output | 16 | Vector value |
| vec_addr | output | 24 | Vector table address |

## Verification
The bound checker watches the following on every cycle:

- The level-mode pass-through of the pin.
- The vector choice against the requests that were present at the read edge.
- That a valid word appears exactly when a read meets an outstanding accept.
- That the receive flag falls only after a buffer-read strobe.
- That an edge-mode pin request drops only after a clear write or a vector read.

Some behaviour needs stimulus sequences that only the bench's directed scenarios provide:

- The asymmetric mode switches (clearing when entering level mode, keeping when leaving it).
- The exact three-edge latency of edge capture.
- Which clear-register codes are ignored.
- The default vector after a clear that falls between accept and read.

// File: rtl/irqlv_pkg.sv
package irqlv_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PIN  = 2'd1,
    SRC_RX   = 2'd2
  } irq_src_e;

  // Fixed priority: pin ahead of receive, none falls to the default vector.
  function automatic irq_src_e pick_src(input logic pin_pend, input logic rx_pend);
    if (pin_pend)     return SRC_PIN;
    else if (rx_pend) return SRC_RX;
    else              return SRC_NONE;
  endfunction

endpackage

// File: rtl/irqlv_regdec.sv
module irqlv_regdec #(
  parameter int          REG_AW    = 2,
  parameter int          REG_DW    = 8,
  parameter int unsigned MODE_ADDR = 0,
  parameter int unsigned CLR_ADDR  = 1,
  parameter int unsigned CLR_CODE  = 8'h0A
) (
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic              mode_wr,
  output logic              mode_val,
  output logic              clr_pin
);
  localparam logic [REG_AW-1:0] MODE_A = REG_AW'(MODE_ADDR);
  localparam logic [REG_AW-1:0] CLR_A  = REG_AW'(CLR_ADDR);
  localparam logic [REG_DW-1:0] CLR_C  = REG_DW'(CLR_CODE);

  logic [REG_DW-1:0] unused_hi;

  always_comb begin
    mode_wr   = reg_wr && (reg_addr == MODE_A);
    mode_val  = reg_wdata[0];
    clr_pin   = reg_wr && (reg_addr == CLR_A) && (reg_wdata == CLR_C);
    unused_hi = reg_wdata;
  end
endmodule

// File: rtl/irqlv_pin_src.sv
module irqlv_pin_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  input  logic mode_wr,
  input  logic mode_val,
  input  logic clr_code,
  input  logic clr_vec,
  output logic pin_req,
  output logic level_mode
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic                   pin_d;
  logic                   rise;
  logic                   flag_q;
  logic                   level_q;
  logic                   enter_level;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_in;
      end
    end
  endgenerate

  always_comb begin
    pin_s       = sync_q[LAST];
    rise        = pin_s && !pin_d;
    enter_level = mode_wr && mode_val && !level_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_d   <= 1'b0;
      level_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pin_d <= pin_s;
      if (mode_wr) level_q <= mode_val;
      if (enter_level) begin
        flag_q <= 1'b0;                 // entering level mode wipes the flag
      end else if (level_q) begin
        flag_q <= pin_s;                // set input passes straight through
      end else if (rise) begin
        flag_q <= 1'b1;                 // a new edge outranks any clear
      end else if (clr_code || clr_vec) begin
        flag_q <= 1'b0;
      end
    end
  end

  always_comb begin
    pin_req    = level_q ? pin_s : flag_q;
    level_mode = level_q;
  end
endmodule

// File: rtl/irqlv_rx_src.sv
module irqlv_rx_src (
  input  logic clk,
  input  logic rst,
  input  logic rx_req,
  input  logic rx_buf_rd,
  output logic rx_flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)            flag_q <= 1'b0;
    else if (rx_req)    flag_q <= 1'b1;
    else if (rx_buf_rd) flag_q <= 1'b0;
  end

  assign rx_flag = flag_q;
endmodule

// File: rtl/irqlv_vector.sv
module irqlv_vector
  import irqlv_pkg::*;
#(
  parameter int          VEC_W    = 16,
  parameter int          ADDR_W   = 24,
  parameter logic [15:0] VEC_PIN  = 16'h0028,
  parameter logic [15:0] VEC_RX   = 16'h0050,
  parameter logic [15:0] VEC_DEF  = 16'h0008,
  parameter logic [23:0] TBL_BASE = 24'hFFFF00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_accept,
  input  logic              ack_vec_rd,
  input  logic              pin_req,
  input  logic              rx_flag,
  input  logic              level_mode,
  output logic              clr_pin,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_out,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam logic [VEC_W-1:0]  V_PIN = VEC_W'(VEC_PIN);
  localparam logic [VEC_W-1:0]  V_RX  = VEC_W'(VEC_RX);
  localparam logic [VEC_W-1:0]  V_DEF = VEC_W'(VEC_DEF);
  localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(TBL_BASE);

  logic             open_q;
  logic             take;
  irq_src_e         src;
  logic [VEC_W-1:0] vec_d;
  logic [VEC_W-1:0] vec_q;
  logic             valid_q;

  always_comb begin
    take = ack_vec_rd && open_q;
    src  = pick_src(pin_req, rx_flag);
    unique case (src)
      SRC_PIN: vec_d = V_PIN;
      SRC_RX:  vec_d = V_RX;
      default: vec_d = V_DEF;
    endcase
    clr_pin = take && (src == SRC_PIN) && !level_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      valid_q <= 1'b0;
      vec_q   <= V_DEF;
    end else begin
      valid_q <= take;
      if (take) begin
        open_q <= 1'b0;
        vec_q  <= vec_d;
      end else if (ack_accept) begin
        open_q <= 1'b1;
      end
    end
  end

  always_comb begin
    vec_valid = valid_q;
    vec_out   = vec_q;
    vec_addr  = BASE + ADDR_W'(vec_q);
  end
endmodule

// File: rtl/irq_latch_vec.sv
module irq_latch_vec #(
  parameter int          SYNC_STAGES = 2,
  parameter int          REG_AW      = 2,
  parameter int          REG_DW      = 8,
  parameter int          VEC_W       = 16,
  parameter int          ADDR_W      = 24,
  parameter int unsigned MODE_ADDR   = 0,
  parameter int unsigned CLR_ADDR    = 1,
  parameter int unsigned CLR_CODE    = 8'h0A,
  parameter logic [15:0] VEC_PIN     = 16'h0028,
  parameter logic [15:0] VEC_RX      = 16'h0050,
  parameter logic [15:0] VEC_DEF     = 16'h0008,
  parameter logic [23:0] TBL_BASE    = 24'hFFFF00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_in,
  input  logic              rx_req,
  input  logic              rx_buf_rd,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              ack_accept,
  input  logic              ack_vec_rd,
  output logic              pin_req,
  output logic              rx_flag,
  output logic              pin_level_mode,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_out,
  output logic [ADDR_W-1:0] vec_addr
);
  logic mode_wr, mode_val, clr_code, clr_vec;

  irqlv_regdec #(
    .REG_AW(REG_AW), .REG_DW(REG_DW), .MODE_ADDR(MODE_ADDR),
    .CLR_ADDR(CLR_ADDR), .CLR_CODE(CLR_CODE)
  ) u_regdec (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mode_wr(mode_wr), .mode_val(mode_val), .clr_pin(clr_code)
  );

  irqlv_pin_src #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst(rst), .pin_in(pin_in), .mode_wr(mode_wr),
    .mode_val(mode_val), .clr_code(clr_code), .clr_vec(clr_vec),
    .pin_req(pin_req), .level_mode(pin_level_mode)
  );

  irqlv_rx_src u_rx (
    .clk(clk), .rst(rst), .rx_req(rx_req), .rx_buf_rd(rx_buf_rd),
    .rx_flag(rx_flag)
  );

  irqlv_vector #(
    .VEC_W(VEC_W), .ADDR_W(ADDR_W), .VEC_PIN(VEC_PIN), .VEC_RX(VEC_RX),
    .VEC_DEF(VEC_DEF), .TBL_BASE(TBL_BASE)
  ) u_vec (
    .clk(clk), .rst(rst), .ack_accept(ack_accept), .ack_vec_rd(ack_vec_rd),
    .pin_req(pin_req), .rx_flag(rx_flag), .level_mode(pin_level_mode),
    .clr_pin(clr_vec), .vec_valid(vec_valid), .vec_out(vec_out),
    .vec_addr(vec_addr)
  );
endmodule

// File: rtl/irqlv_chk.sv
module irqlv_chk #(
  parameter int          SYNC_STAGES = 2,
  parameter int          REG_AW      = 2,
  parameter int          REG_DW      = 8,
  parameter int          VEC_W       = 16,
  parameter int unsigned CLR_ADDR    = 1,
  parameter int unsigned CLR_CODE    = 8'h0A,
  parameter logic [15:0] VEC_PIN     = 16'h0028,
  parameter logic [15:0] VEC_RX      = 16'h0050,
  parameter logic [15:0] VEC_DEF     = 16'h0008
) (
  input logic              clk,
  input logic              rst,
  input logic              pin_in,
  input logic              rx_req,
  input logic              rx_buf_rd,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic              ack_accept,
  input logic              ack_vec_rd,
  input logic              pin_req,
  input logic              rx_flag,
  input logic              pin_level_mode,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec_out
);
  logic [3:0] since_rst;
  logic       open_q;
  logic       clr_wr;

  assign clr_wr = reg_wr && (reg_addr == REG_AW'(CLR_ADDR)) &&
                  (reg_wdata == REG_DW'(CLR_CODE));

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      open_q    <= 1'b0;
    end else begin
      if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
      if (ack_vec_rd && open_q) open_q <= 1'b0;
      else if (ack_accept)      open_q <= 1'b1;
    end
  end

  p_level_follows_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 4'(SYNC_STAGES) && pin_level_mode) |->
      (pin_req == $past(pin_in, SYNC_STAGES)));

  p_vector_choice_r8: assert property (@(posedge clk) disable iff (rst)
    vec_valid |->
      (vec_out == ($past(pin_req) ? VEC_W'(VEC_PIN) :
                   $past(rx_flag) ? VEC_W'(VEC_RX) : VEC_W'(VEC_DEF))));

  p_default_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !$past(pin_req) && !$past(rx_flag)) |->
      (vec_out == VEC_W'(VEC_DEF)));

  p_valid_needs_accept_r11: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(ack_vec_rd && open_q));

  p_read_gives_valid_r11: assert property (@(posedge clk) disable iff (rst)
    (ack_vec_rd && open_q) |=> vec_valid);

  p_rx_set_r7: assert property (@(posedge clk) disable iff (rst)
    rx_req |=> rx_flag);

  p_rx_fall_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_flag) |-> $past(rx_buf_rd));

  p_edge_drop_cause_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(pin_req) && !pin_level_mode && $past(!pin_level_mode)) |->
      ($past(clr_wr) || $past(ack_vec_rd)));
endmodule

bind irq_latch_vec irqlv_chk #(
  .SYNC_STAGES(SYNC_STAGES), .REG_AW(REG_AW), .REG_DW(REG_DW), .VEC_W(VEC_W),
  .CLR_ADDR(CLR_ADDR), .CLR_CODE(CLR_CODE), .VEC_PIN(VEC_PIN),
  .VEC_RX(VEC_RX), .VEC_DEF(VEC_DEF)
) u_irqlv_chk (
  .clk(clk), .rst(rst), .pin_in(pin_in), .rx_req(rx_req),
  .rx_buf_rd(rx_buf_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ack_accept(ack_accept), .ack_vec_rd(ack_vec_rd),
  .pin_req(pin_req), .rx_flag(rx_flag), .pin_level_mode(pin_level_mode),
  .vec_valid(vec_valid), .vec_out(vec_out)
);

// File: tb/tb_irq_latch_vec.sv
module tb_irq_latch_vec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_in = 1'b0, rx_req = 1'b0, rx_buf_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        ack_accept = 1'b0, ack_vec_rd = 1'b0;
  logic        pin_req, rx_flag, pin_level_mode, vec_valid;
  logic [15:0] vec_out;
  logic [23:0] vec_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_latch_vec dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .rx_req(rx_req),
    .rx_buf_rd(rx_buf_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ack_accept(ack_accept), .ack_vec_rd(ack_vec_rd),
    .pin_req(pin_req), .rx_flag(rx_flag), .pin_level_mode(pin_level_mode),
    .vec_valid(vec_valid), .vec_out(vec_out), .vec_addr(vec_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic accept();
    ack_accept = 1'b1; tick(1); ack_accept = 1'b0;
  endtask

  task automatic vec_read();
    ack_vec_rd = 1'b1; tick(1); ack_vec_rd = 1'b0;
  endtask

  task automatic rx_pulse();
    rx_req = 1'b1; tick(1); rx_req = 1'b0;
  endtask

  task automatic rx_read();
    rx_buf_rd = 1'b1; tick(1); rx_buf_rd = 1'b0;
  endtask

  task automatic edge_set();  // latch a pin edge, then pin back low
    pin_in = 1'b1; tick(3); pin_in = 1'b0; tick(2);
  endtask

  task automatic t_reset();
    chk("R1 pin_req", pin_req, 0);
    chk("R1 rx_flag", rx_flag, 0);
    chk("R1 vec_valid", vec_valid, 0);
    chk("R1 mode", pin_level_mode, 0);
  endtask

  task automatic t_edge_capture();
    pin_in = 1'b1; tick(2);
    chk("R2 before third edge", pin_req, 0);
    tick(1);
    chk("R2 third edge", pin_req, 1);
    pin_in = 1'b0; tick(4);
    chk("R2 held after fall", pin_req, 1);
    wr(2'd1, 8'h05);
    chk("R6 other code ignored", pin_req, 1);
    wr(2'd1, 8'h0A);
    chk("R6 clear code", pin_req, 0);
  endtask

  task automatic t_level_follow();
    wr(2'd0, 8'h01);
    chk("R12 level selected", pin_level_mode, 1);
    pin_in = 1'b1; tick(1);
    chk("R3 one edge", pin_req, 0);
    tick(1);
    chk("R3 two edges", pin_req, 1);
    pin_in = 1'b0; tick(2);
    chk("R3 fall removes", pin_req, 0);
  endtask

  task automatic t_enter_level();
    wr(2'd0, 8'h00);
    edge_set();
    chk("R4 latched first", pin_req, 1);
    wr(2'd0, 8'h01);
    chk("R4 level entry drops", pin_req, 0);
    wr(2'd0, 8'h00);
    chk("R4 stays cleared in edge", pin_req, 0);
  endtask

  task automatic t_leave_level();
    wr(2'd0, 8'h01);
    pin_in = 1'b1; tick(3);
    chk("R5 level high", pin_req, 1);
    wr(2'd0, 8'h00);
    chk("R12 edge selected", pin_level_mode, 0);
    pin_in = 1'b0; tick(4);
    chk("R5 kept after leave", pin_req, 1);
    wr(2'd1, 8'h0A);
    chk("R5 explicit clear", pin_req, 0);
  endtask

  task automatic t_mode_addr();
    wr(2'd2, 8'h01);
    chk("R12 addr2 ignored", pin_level_mode, 0);
    wr(2'd1, 8'h01);
    chk("R12 addr1 ignored", pin_level_mode, 0);
  endtask

  task automatic t_rx_rules();
    rx_pulse();
    chk("R7 set", rx_flag, 1);
    wr(2'd1, 8'h0A);
    chk("R7 clear code ignored", rx_flag, 1);
    wr(2'd1, 8'hFF);
    tick(5);
    chk("R7 still held", rx_flag, 1);
    rx_read();
    chk("R7 buffer read clears", rx_flag, 0);
  endtask

  task automatic t_vector_priority();
    edge_set();
    rx_pulse();
    accept(); tick(2);
    vec_read();
    chk("R8 valid", vec_valid, 1);
    chk("R8 pin wins", vec_out, 16'h0028);
    chk("R10 edge pin cleared", pin_req, 0);
    chk("R10 rx kept", rx_flag, 1);
    tick(1);
    chk("R8 one cycle valid", vec_valid, 0);
    accept();
    vec_read();
    chk("R8 rx vector", vec_out, 16'h0050);
    chk("R8 rx address", vec_addr, 24'hFFFF50);
    chk("R10 rx still set", rx_flag, 1);
    rx_read();
  endtask

  task automatic t_default_vector();
    edge_set();
    chk("R9 pending before", pin_req, 1);
    accept();
    wr(2'd1, 8'h0A);
    vec_read();
    chk("R9 valid", vec_valid, 1);
    chk("R9 default vector", vec_out, 16'h0008);
    chk("R9 default address", vec_addr, 24'hFFFF08);
  endtask

  task automatic t_no_accept();
    vec_read();
    chk("R11 read without accept", vec_valid, 0);
    accept();
    vec_read();
    chk("R11 first read", vec_valid, 1);
    vec_read();
    chk("R11 second read ignored", vec_valid, 0);
  endtask

  task automatic t_level_vector();
    wr(2'd0, 8'h01);
    pin_in = 1'b1; tick(2);
    accept();
    vec_read();
    chk("R8 level pin vector", vec_out, 16'h0028);
    chk("R10 level not cleared", pin_req, 1);
    pin_in = 1'b0; tick(2);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    t_edge_capture();
    t_level_follow();
    t_enter_level();
    t_leave_level();
    t_mode_addr();
    t_rx_rules();
    t_vector_priority();
    t_default_vector();
    t_no_accept();
    t_level_vector();
    tick(2);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule